// File: doc/BRIEF.md
# Sigma-Delta Pulse DAC Modulator

This block converts an unsigned digital level into a single-bit pulse stream. An external RC low-pass filter averages the stream back into an analog voltage. The core is a first-order error-feedback modulator. On every bit period it adds the active code to a running remainder, and the carry out of that addition becomes the bit for the period. Over time the density of ones matches the code. The ones are spread through the stream rather than grouped into a single pulse.

Software-side logic loads a new level, a resolution select and a waveform select through a one-cycle write strobe. In the narrow resolution, the low-order input bits are shifted up and zero-filled at the bottom, so the same modulator serves both widths. Each bit period spans two equal half-periods. In non-return-to-zero shaping a one holds the pin high for the whole period. In return-to-zero shaping a one is high only in the first half, which gives every one its own rising and falling edge and halves the full-scale level. A written setting takes effect at the next bit-period boundary. The remainder is kept across code changes.

Top module: `sd_pulse_dac`

## Requirements
- R1: While `rst` is high, and after it is released with no write, `dac_out` stays low. Reset clears the remainder to 0, loads a held code of 0, selects full resolution (`wr_narrow`=0) and selects non-return-to-zero shaping (`wr_rtz`=0).
- R2: At each bit-period boundary the remainder r and the effective code c form s = r + c (17 bits). The period's bit is s[16] and r becomes s[15:0]. From r=0 with code 0x8000, the bits of the first four periods are 0,1,0,1.
- R3: With `wr_narrow`=1, the effective code is `wr_code[13:0]` followed by two zero bits (`wr_code[13:0]`<<2), and `wr_code[15:14]` has no effect. A raw value of 0xD000 therefore behaves as 0x4000, giving exactly 16 ones in 64 periods.
- R4: With `wr_rtz`=0, `dac_out` equals the period's bit for both halves of the period. There is no edge inside a period.
- R5: With `wr_rtz`=1, `dac_out` equals the period's bit in the first half and is low in the second half.
- R6: A write (`wr_en`=1) sampled at a clock edge takes effect at the first bit-period boundary at or after that edge. The remainder is not cleared when the setting changes, and the current period's output is unchanged.
- R7: A code of 0 keeps `dac_out` low in every period.
- R8: A code of 0xFFFF gives a one in every period except one in each 65536 periods.
- R9: For a fixed code, any window of 65536 whole bit periods holds exactly as many ones as the code's value. A code of 0x0100 gives exactly one in 256 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per half bit period at the default setting |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe that captures the three settings below |
| wr_code | input | CODE_W | Unsigned level code |
| wr_narrow | input | 1 | 1: narrow resolution with zero-padded low bits; 0: full resolution |
| wr_rtz | input | 1 | 1: return-to-zero shaping; 0: non-return-to-zero shaping |
| dac_out | output | 1 | Registered one-bit pulse stream |

## Verification
The bench builds the block with its defaults: a 16-bit code, a 14-bit narrow width, and a half-period of one clock. With two clocks per bit, a full 65536-period window of an all-ones code fits in the run, so the exact one-count property can be checked at its hardest value. Shorter windows, whose length is set by the code's power-of-two factors, confirm the padding in the narrow mode. Random codes, random shaping and writes at random phases are compared cycle by cycle against a bench model of the remainder.

// File: rtl/sd_pulse_pkg.sv
package sd_pulse_pkg;
  typedef enum logic {
    RES_FULL   = 1'b0,
    RES_NARROW = 1'b1
  } res_e;

  typedef enum logic {
    SHAPE_NRZ = 1'b0,
    SHAPE_RTZ = 1'b1
  } shape_e;
endpackage

// File: rtl/sd_code_align.sv
module sd_code_align
  import sd_pulse_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 14
) (
  input  logic [CODE_W-1:0] raw_code,
  input  res_e              res_sel,
  output logic [CODE_W-1:0] aligned_code
);
  localparam int PAD_W = CODE_W - NARROW_W;

  always_comb begin
    if (res_sel == RES_NARROW) begin
      aligned_code = {raw_code[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin
      aligned_code = raw_code;
    end
  end
endmodule

// File: rtl/sd_err_accum.sv
module sd_err_accum #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              carry
);
  logic [CODE_W-1:0] rem_q;
  logic [CODE_W:0]   sum;

  always_comb begin
    sum   = {1'b0, rem_q} + {1'b0, code};
    carry = sum[CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (step) begin
      rem_q <= sum[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/sd_shaper.sv
module sd_shaper #(
  parameter int HALF_LEN = 1,
  localparam int PER_LEN = 2 * HALF_LEN,
  localparam int PH_W    = (PER_LEN > 1) ? $clog2(PER_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            carry,
  input  logic            rtz_next,
  output logic            step,
  output logic [PH_W-1:0] ph_q,
  output logic            rtz_q,
  output logic            pin_q
);
  localparam int PH_LAST = PER_LEN - 1;
  localparam int PH_MID  = HALF_LEN - 1;

  assign step = (ph_q == PH_W'(PH_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_W'(PH_LAST);
      pin_q <= 1'b0;
      rtz_q <= 1'b0;
    end else if (step) begin
      ph_q  <= '0;
      pin_q <= carry;
      rtz_q <= rtz_next;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (ph_q == PH_W'(PH_MID) && rtz_q) begin
        pin_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sd_pulse_dac.sv
module sd_pulse_dac
  import sd_pulse_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 14,
  parameter int HALF_LEN = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_narrow,
  input  logic              wr_rtz,
  output logic              dac_out
);
  localparam int PER_LEN = 2 * HALF_LEN;
  localparam int PH_W    = (PER_LEN > 1) ? $clog2(PER_LEN) : 1;

  logic [CODE_W-1:0] wr_aligned;
  logic [CODE_W-1:0] held_code, act_code, eff_code;
  res_e              held_res, act_res, eff_res;
  shape_e            held_shape, eff_shape;
  logic              step, carry, rtz_act;
  logic [PH_W-1:0]   ph_q;
  logic              act_narrow;

  sd_code_align #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) align_i (
    .raw_code    (wr_code),
    .res_sel     (res_e'(wr_narrow)),
    .aligned_code(wr_aligned)
  );

  always_comb begin
    eff_code  = wr_en ? wr_aligned : held_code;
    eff_res   = wr_en ? res_e'(wr_narrow) : held_res;
    eff_shape = wr_en ? shape_e'(wr_rtz) : held_shape;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_code  <= '0;
      held_res   <= RES_FULL;
      held_shape <= SHAPE_NRZ;
    end else if (wr_en) begin
      held_code  <= wr_aligned;
      held_res   <= res_e'(wr_narrow);
      held_shape <= shape_e'(wr_rtz);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_code <= '0;
      act_res  <= RES_FULL;
    end else if (step) begin
      act_code <= eff_code;
      act_res  <= eff_res;
    end
  end

  assign act_narrow = (act_res == RES_NARROW);

  sd_err_accum #(.CODE_W(CODE_W)) accum_i (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .code (eff_code),
    .carry(carry)
  );

  sd_shaper #(.HALF_LEN(HALF_LEN)) shaper_i (
    .clk     (clk),
    .rst     (rst),
    .carry   (carry),
    .rtz_next(eff_shape == SHAPE_RTZ),
    .step    (step),
    .ph_q    (ph_q),
    .rtz_q   (rtz_act),
    .pin_q   (dac_out)
  );
endmodule

// File: rtl/sd_pulse_dac_chk.sv
module sd_pulse_dac_chk #(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 14,
  parameter int HALF_LEN = 1,
  localparam int PER_LEN = 2 * HALF_LEN,
  localparam int PH_W    = (PER_LEN > 1) ? $clog2(PER_LEN) : 1,
  localparam int PAD_W   = CODE_W - NARROW_W
) (
  input logic              clk,
  input logic              rst,
  input logic              dac_out,
  input logic [PH_W-1:0]   ph_q,
  input logic              rtz_act,
  input logic [CODE_W-1:0] act_code,
  input logic              act_narrow
);
  AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dac_out); // R1

  AST_NARROW_PAD: assert property (@(posedge clk) disable iff (rst)
    act_narrow |-> (act_code[PAD_W-1:0] == '0)); // R3

  AST_NRZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph_q != '0 && !rtz_act) |-> $stable(dac_out)); // R4

  AST_RTZ_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (rtz_act && ph_q >= PH_W'(HALF_LEN)) |-> !dac_out); // R5

  AST_ZERO_CODE_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_code == '0) |-> !dac_out); // R7
endmodule

bind sd_pulse_dac sd_pulse_dac_chk #(
  .CODE_W(CODE_W), .NARROW_W(NARROW_W), .HALF_LEN(HALF_LEN)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .dac_out   (dac_out),
  .ph_q      (ph_q),
  .rtz_act   (rtz_act),
  .act_code  (act_code),
  .act_narrow(act_narrow)
);

// File: tb/sd_pulse_dac_tb_top.sv
`timescale 1ns/1ps
module sd_pulse_dac_tb_top;
  localparam int CODE_W   = 16;
  localparam int NARROW_W = 14;
  localparam int HALF     = 1;
  localparam int LAST     = 2 * HALF - 1;
  localparam int FULL     = 1 << CODE_W;
  localparam int WD_LIMIT = 190000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [CODE_W-1:0] wr_code = '0;
  logic              wr_narrow = 1'b0;
  logic              wr_rtz = 1'b0;
  logic              dac_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int m_ph, m_acc, m_hcode;
  bit m_pin, m_rtz, m_hrtz;

  // observation counters
  int seg_err = 0;
  int ones = 0;
  int hi2 = 0;
  int split = 0;
  bit first_half;
  logic [7:0] pat;

  always #2.5 clk = ~clk;

  sd_pulse_dac #(.CODE_W(CODE_W), .NARROW_W(NARROW_W), .HALF_LEN(HALF)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .wr_narrow(wr_narrow), .wr_rtz(wr_rtz), .dac_out(dac_out)
  );

  function automatic int pad_code(int raw, bit nar);
    if (nar) return (raw & ((1 << NARROW_W) - 1)) << (CODE_W - NARROW_W);
    return raw & (FULL - 1);
  endfunction

  always @(posedge clk) begin
    int e_code, sum;
    bit e_rtz;
    if (rst) begin
      m_ph = LAST; m_pin = 0; m_acc = 0; m_hcode = 0; m_hrtz = 0; m_rtz = 0;
    end else begin
      e_code = wr_en ? pad_code(int'(wr_code), wr_narrow) : m_hcode;
      e_rtz  = wr_en ? wr_rtz : m_hrtz;
      if (m_ph == LAST) begin
        sum   = m_acc + e_code;
        m_pin = (sum >= FULL);
        m_acc = sum % FULL;
        m_rtz = e_rtz;
        m_ph  = 0;
      end else begin
        if (m_ph == HALF - 1 && m_rtz) m_pin = 0;
        m_ph = m_ph + 1;
      end
      if (wr_en) begin
        m_hcode = e_code;
        m_hrtz  = wr_rtz;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    seg_err = 0; ones = 0; hi2 = 0; split = 0; pat = '0;
  endtask

  task automatic tick();
    if (dac_out !== m_pin) seg_err++;
    if (m_ph == 0) begin
      first_half = dac_out;
      if (dac_out) ones++;
      pat = {pat[6:0], dac_out};
    end
    if (m_ph >= HALF) begin
      if (dac_out) hi2++;
      if (!m_rtz && dac_out !== first_half) split++;
    end
    @(negedge clk);
  endtask

  task automatic load(int code, bit nar, bit rtz);
    wr_en = 1; wr_code = code[CODE_W-1:0]; wr_narrow = nar; wr_rtz = rtz;
    tick();
    wr_en = 0; wr_code = '0; wr_narrow = 0; wr_rtz = 0;
    while (m_ph != 0) tick();
  endtask

  task automatic run_periods(int n);
    for (int i = 0; i < n * 2 * HALF; i++) tick();
  endtask

  initial begin
    void'($urandom(32'd5192));
    repeat (4) @(negedge clk);
    check(dac_out == 1'b0, "R1 in reset", dac_out, 0);
    rst = 0;
    clear_obs();
    run_periods(20);
    check(ones == 0 && seg_err == 0, "R1 after release", ones, 0);

    // R2 directed: remainder starts at 0
    load(16'h8000, 0, 0);
    clear_obs();
    run_periods(4);
    check(pat[3:0] == 4'b0101, "R2 pattern 0x8000", int'(pat[3:0]), 5);

    // R2 random codes, full resolution, nRTZ; R4 no mid-period edge
    for (int k = 0; k < 6; k++) begin
      load(int'($urandom % FULL), 0, 0);
      clear_obs();
      run_periods(300);
      check(seg_err == 0, "R2 random code", seg_err, 0);
      check(split == 0, "R4 nrz whole period", split, 0);
    end

    // R5 random codes in RTZ
    for (int k = 0; k < 4; k++) begin
      load(int'($urandom % FULL), 0, 1);
      clear_obs();
      run_periods(300);
      check(seg_err == 0, "R5 rtz model", seg_err, 0);
      check(hi2 == 0, "R5 rtz second half low", hi2, 0);
    end
    load(16'hFFFF, 0, 1);
    clear_obs();
    run_periods(64);
    check(ones >= 63 && hi2 == 0, "R5 rtz full scale", hi2, 0);

    // R3 narrow: raw 0xD000 acts as 0x4000
    load(16'hD000, 1, 0);
    clear_obs();
    run_periods(64);
    check(ones == 16, "R3 narrow padding", ones, 16);
    check(seg_err == 0, "R3 narrow model", seg_err, 0);

    // R6 writes at random phases, remainder carried across changes
    clear_obs();
    for (int k = 0; k < 40; k++) begin
      int gap;
      gap = int'($urandom % 7);
      for (int g = 0; g < gap; g++) tick();
      wr_en = 1; wr_code = 16'($urandom); wr_narrow = 1'($urandom); wr_rtz = 1'($urandom);
      tick();
      wr_en = 0;
      run_periods(int'($urandom % 5));
    end
    check(seg_err == 0, "R6 update at boundary", seg_err, 0);

    // R7 zero code
    load(0, 0, 0);
    clear_obs();
    run_periods(200);
    check(ones == 0 && hi2 == 0, "R7 zero code low", ones, 0);

    // R9 short window, code 0x0100
    load(16'h0100, 0, 0);
    clear_obs();
    run_periods(256);
    check(ones == 1, "R9 window 0x0100", ones, 1);

    // R8 / R9 full window, all ones
    load(16'hFFFF, 0, 0);
    clear_obs();
    run_periods(FULL);
    check(ones == FULL - 1, "R8 all-ones window", ones, FULL - 1);
    check(seg_err == 0, "R9 all-ones model", seg_err, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule